// File: doc/BRIEF.md
# Power-On Reset Release Sequencer

This block brings a chip out of reset in a fixed order after power-up. An external run input and a core-supply-good flag must both be high before anything happens. The sequencer then enables the internal oscillator and waits for it to report a stable clock. After that it releases one reset group at a time, with a programmable gap between releases, and last of all it raises a processor start.

A falling run input or a dropped supply flag in any state puts every output back into reset at once. The sequencer then returns to its initial state, and the next power-up runs the full sequence again. The three status inputs are asynchronous to the clock, so each passes through a synchronizer of `SYNC_STAGES` flops before the state machine sees it. All outputs are registers.

Top module: `por_seq_top`

## Requirements
- R1: While run_in is low, grp_rst is all ones and osc_en, cpu_start and done are 0, whatever supply_ok and osc_stable do.
- R2: While supply_ok is low, the sequence does not advance: osc_en stays 0 and every group stays in reset.
- R3: osc_en rises SYNC_STAGES+1 cycles after run_in and supply_ok are both high. No group is released while osc_stable is low.
- R4: The groups are released in index order, with bit 0 = reset controller, bit 1 = execute-in-place logic and memories, bit 2 = bus fabric and bit 3 = processor subsystem. Bit k falls SYNC_STAGES+1+GAP_CYCLES*(k+1) cycles after osc_stable rises. A released bit (0) never comes back while the run is in progress.
- R5: cpu_start rises GAP_CYCLES cycles after the last group is released, and it is high only while every bit of grp_rst is 0.
- R6: done rises one cycle after cpu_start and is high only while cpu_start is high.
- R7: If run_in or supply_ok falls in any state, all outputs return to their reset values within SYNC_STAGES+1 cycles. A later power-up repeats the sequence with identical timing.
- R8: The synchronous input rst forces the reset values on all outputs at the next edge.
- R9: Once done is high, a drop of osc_stable has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_in | input | 1 | External run request (asynchronous); low holds the chip in reset |
| supply_ok | input | 1 | Core supply stable flag (asynchronous) |
| osc_stable | input | 1 | Oscillator stable flag (asynchronous) |
| osc_en | output | 1 | Enable for the internal oscillator |
| grp_rst | output | NGRP | Per-group reset, active high, bit 0 released first |
| cpu_start | output | 1 | Processor start, level |
| done | output | 1 | Sequence complete |

## Verification
A wrong state or stage index shows up at the ports as a group released early, late or out of order. It can also show up as a start that arrives before all groups are free, or an abort that leaves a group released. The release times are fixed arithmetic functions of the synchronizer depth and the gap, so any such fault is visible in the first cycle that differs. The bench therefore compares every output in every cycle of a full power-up. It also aborts the run at each cycle in turn, by dropping either run_in or supply_ok, and requires full reset exactly SYNC_STAGES+1 cycles later.

// File: rtl/por_pkg.sv
package por_pkg;
  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,
    ST_OSC  = 2'd1,
    ST_STEP = 2'd2,
    ST_RUN  = 2'd3
  } por_state_e;
endpackage

// File: rtl/por_sync.sv
module por_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= '0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/por_gap_timer.sv
module por_gap_timer #(
  parameter int GAP = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);
  localparam int CW = (GAP < 2) ? 1 : $clog2(GAP);
  localparam logic [CW-1:0] RELOAD = CW'(GAP - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= RELOAD;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R4: a load always starts a countdown of exactly GAP-1 remaining
  p_reload_r4: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == RELOAD));
endmodule

// File: rtl/por_fsm.sv
module por_fsm
  import por_pkg::*;
#(
  parameter int NGRP = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run_s,
  input  logic            pwr_s,
  input  logic            osc_s,
  input  logic            tmr_done,
  output logic            tmr_load,
  output logic            osc_en,
  output logic [NGRP-1:0] grp_rst,
  output logic            cpu_start,
  output logic            done
);
  localparam int IW = $clog2(NGRP + 1);
  localparam logic [IW-1:0] LAST = IW'(NGRP);

  por_state_e    st;
  logic [IW-1:0] idx;
  logic          abort;

  assign abort = rst || !run_s || !pwr_s;

  assign tmr_load = ((st == ST_OSC) && osc_s) ||
                    ((st == ST_STEP) && tmr_done && (idx != LAST));

  always_ff @(posedge clk) begin
    if (abort) begin
      st        <= ST_HOLD;
      idx       <= '0;
      osc_en    <= 1'b0;
      grp_rst   <= '1;
      cpu_start <= 1'b0;
      done      <= 1'b0;
    end else begin
      case (st)
        ST_HOLD: begin
          osc_en <= 1'b1;
          st     <= ST_OSC;
        end
        ST_OSC: begin
          idx <= '0;
          if (osc_s) st <= ST_STEP;
        end
        ST_STEP: begin
          if (tmr_done) begin
            if (idx == LAST) begin
              cpu_start <= 1'b1;
              st        <= ST_RUN;
            end else begin
              for (int k = 0; k < NGRP; k++)
                if (idx == IW'(k)) grp_rst[k] <= 1'b0;
              idx <= idx + 1'b1;
            end
          end
        end
        ST_RUN: done <= 1'b1;
        default: st <= ST_HOLD;
      endcase
    end
  end

  // R1: run low forces the full reset state on the following edge
  p_run_low_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !run_s |=> (grp_rst == '1 && !osc_en && !cpu_start && !done && st == ST_HOLD));

  // R2: supply low forces the full reset state on the following edge
  p_supply_low_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !pwr_s |=> (grp_rst == '1 && !osc_en && !cpu_start && !done));

  // R3: no group leaves reset without the oscillator enabled
  p_osc_first_r3: assert property (@(posedge clk) disable iff (rst)
    (grp_rst != '1) |-> osc_en);

  // R5: processor start only with every group released
  p_start_after_all_r5: assert property (@(posedge clk) disable iff (rst)
    cpu_start |-> (grp_rst == '0));

  // R6: done only follows the start
  p_done_after_start_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(cpu_start));

  // R9: completed sequence holds while run and supply stay good
  p_run_holds_r9: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && run_s && pwr_s) |=> (grp_rst == '0 && cpu_start));

  generate
    for (genvar k = 1; k < NGRP; k++) begin : g_order
      // R4: group k is released only after group k-1
      p_order_r4: assert property (@(posedge clk) disable iff (rst)
        !grp_rst[k] |-> !grp_rst[k-1]);
    end
  endgenerate
endmodule

// File: rtl/por_seq_top.sv
module por_seq_top #(
  parameter int NGRP        = 4,
  parameter int GAP_CYCLES  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run_in,
  input  logic            supply_ok,
  input  logic            osc_stable,
  output logic            osc_en,
  output logic [NGRP-1:0] grp_rst,
  output logic            cpu_start,
  output logic            done
);
  logic [2:0] raw_in;
  logic [2:0] sync_in;
  logic       tmr_load;
  logic       tmr_done;

  assign raw_in = {osc_stable, supply_ok, run_in};

  por_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (sync_in)
  );

  por_gap_timer #(.GAP(GAP_CYCLES)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .expired (tmr_done)
  );

  por_fsm #(.NGRP(NGRP)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .run_s     (sync_in[0]),
    .pwr_s     (sync_in[1]),
    .osc_s     (sync_in[2]),
    .tmr_done  (tmr_done),
    .tmr_load  (tmr_load),
    .osc_en    (osc_en),
    .grp_rst   (grp_rst),
    .cpu_start (cpu_start),
    .done      (done)
  );
endmodule

// File: tb/por_seq_top_test.sv
module por_seq_top_test;
  localparam int N   = 4;
  localparam int GAP = 3;
  localparam int S   = 2;
  localparam int T_START = S + 1 + GAP * (N + 1);
  localparam int T_END   = T_START + 3;
  localparam int VW = N + 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_in = 1'b0, supply_ok = 1'b0, osc_stable = 1'b0;
  logic osc_en, cpu_start, done;
  logic [N-1:0] grp_rst;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  por_seq_top #(.NGRP(N), .GAP_CYCLES(GAP), .SYNC_STAGES(S)) uut (
    .clk(clk), .rst(rst), .run_in(run_in), .supply_ok(supply_ok),
    .osc_stable(osc_stable), .osc_en(osc_en), .grp_rst(grp_rst),
    .cpu_start(cpu_start), .done(done)
  );

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  function automatic logic [VW-1:0] got_vec();
    return {done, cpu_start, osc_en, grp_rst};
  endfunction

  localparam logic [VW-1:0] RESET_VEC = {3'b000, {N{1'b1}}};

  // expected outputs c ticks after osc_stable rose (with run and supply high)
  function automatic logic [VW-1:0] exp_after_osc(input int c);
    logic [N-1:0] r;
    for (int k = 0; k < N; k++) r[k] = !(c >= S + 1 + GAP * (k + 1));
    return {(c >= T_START + 1), (c >= T_START), 1'b1, r};
  endfunction

  task automatic check(input string req, input logic [VW-1:0] exp);
    logic [VW-1:0] g;
    g = got_vec();
    checks++;
    if (g !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, g, exp, $time);
    end
  endtask

  task automatic quiesce();
    run_in = 1'b0; supply_ok = 1'b0; osc_stable = 1'b0;
    tick(S + 2);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    tick(3);
    check("R8 reset state", RESET_VEC);
    rst = 1'b0;

    // R1: run low, other inputs high
    supply_ok = 1'b1; osc_stable = 1'b1;
    for (int i = 0; i < 20; i++) begin
      tick(1);
      check("R1 run low holds reset", RESET_VEC);
    end
    quiesce();

    // R2: run high, supply low
    run_in = 1'b1; osc_stable = 1'b1;
    for (int i = 0; i < 20; i++) begin
      tick(1);
      check("R2 supply low no advance", RESET_VEC);
    end
    quiesce();

    // R3: oscillator never stable
    run_in = 1'b1; supply_ok = 1'b1;
    for (int c = 1; c <= 25; c++) begin
      tick(1);
      check("R3 osc enable then wait",
            (c >= S + 1) ? {3'b001, {N{1'b1}}} : RESET_VEC);
    end
    quiesce();

    // R4 R5 R6 R7: abort at every cycle, through each input
    for (int src = 0; src < 2; src++) begin
      for (int t = 0; t <= T_END; t++) begin
        quiesce();
        run_in = 1'b1; supply_ok = 1'b1;
        tick(S + 1);
        check("R3 osc_en timing", {3'b001, {N{1'b1}}});
        osc_stable = 1'b1;
        for (int c = 1; c <= t; c++) begin
          tick(1);
          check("R4 R5 R6 release order and timing", exp_after_osc(c));
        end
        if (src == 0) run_in = 1'b0;
        else          supply_ok = 1'b0;
        tick(S + 1);
        check(src == 0 ? "R7 abort by run" : "R7 abort by supply", RESET_VEC);
      end
    end

    // R9: oscillator flag drop after completion
    quiesce();
    run_in = 1'b1; supply_ok = 1'b1;
    tick(S + 1);
    osc_stable = 1'b1;
    tick(T_END);
    check("R9 completed", exp_after_osc(T_END));
    osc_stable = 1'b0;
    for (int i = 0; i < 10; i++) begin
      tick(1);
      check("R9 osc drop ignored", {3'b111, {N{1'b0}}});
    end

    // R8: synchronous reset mid-run
    rst = 1'b1;
    tick(1);
    check("R8 reset mid-run", RESET_VEC);
    rst = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule